// File: doc/BRIEF.md
# Register-Driven Multiply/Divide Peripheral

This block is an arithmetic helper that sits on a processor's local register bus. Software writes byte-wide operands into a small offset map. One write to a designated offset starts the arithmetic; there is no separate go command. An unsigned 8x8 multiply starts when the second factor is written. An unsigned 16-by-8 divide starts when the divisor is written. The results are read back a byte at a time from a second, read-only offset map.

The multiply produces one partial product per clock and finishes after 8 cycles. The divide resolves one quotient bit per clock and finishes after 16 cycles. The quotient has its own 16-bit register. The product and the remainder share a single 16-bit result register, so whichever operation ran last owns it.

The result registers change every cycle while an operation runs, so an early read returns a partial value. A start write issued during an operation drops the old one and begins again from the operands held at that moment. A busy output is high for exactly the cycles in which an operation is stepping.

Top module: `mulDivUnit`

## Requirements
- R1: After reset, busy is 0 and every readable byte (offsets 0 to 7) reads 0.
- R2: A write to write offset 1 (second factor B), with factor A held from write offset 0, starts an unsigned multiply. The 16-bit product A*B appears at read offsets 2 (low byte) and 3 (high byte) on the 8th rising edge after the write edge.
- R3: The dividend is written as two bytes: low byte at write offset 2, high byte at write offset 3. Writes to offsets 0, 2 and 3 start nothing: busy stays 0 and the readable results do not change.
- R4: A write to write offset 4 (8-bit divisor d) starts an unsigned divide of the held dividend n. On the 16th rising edge after the write edge, the quotient n/d is readable at read offsets 0 (low) and 1 (high), and the remainder n mod d at read offsets 2 (low) and 3 (high).
- R5: A divide by zero returns quotient 0xFFFF and a remainder equal to the dividend.
- R6: The product and the remainder share read offsets 2 and 3, and the last operation decides their value. A multiply leaves the quotient at read offsets 0 and 1 unchanged.
- R7: While a multiply runs, after k of its steps (1 <= k <= 8) the result register holds A*(B mod 2^k).
- R8: A start write during an operation abandons that operation. The new operation runs its full length with the newly written operand and the held operands.
- R9: busy rises on the edge of a start write. It stays high for exactly 8 cycles for a multiply and 16 for a divide, then falls.
- R10: Read offsets 4 to 7 always return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for one cycle |
| wrAddr | input | 3 | Write offset (0 factor A, 1 factor B/start, 2 dividend low, 3 dividend high, 4 divisor/start) |
| wrData | input | 8 | Write data byte |
| rdAddr | input | 3 | Read offset (0/1 quotient low/high, 2/3 result low/high) |
| rdData | output | 8 | Combinational read data byte |
| busy | output | 1 | High while an operation is stepping |

## Verification
The bench targets these corner cases:
- All-zero and all-ones operands. A carry or borrow sized one bit too narrow gives a wrong top byte here.
- A zero divisor. A design that special-cases it wrongly, or lets the trial subtraction misbehave, returns something other than 0xFFFF and the dividend.
- The exact cycle in which busy falls, and the product sampled after every intermediate step. An off-by-one step counter or a multiplier that shifts the wrong way fails both.
- A restart in the middle of an operation, a divide after a multiply, and a multiply after a divide. A design that finishes the old job early, or writes the product over the quotient, shows the wrong value in the shared result register or in the quotient.

// File: rtl/mduPkg.sv
package mduPkg;

  localparam int ADDR_W = 3;

  // write offsets
  localparam logic [ADDR_W-1:0] WR_FACT_A  = 3'd0;
  localparam logic [ADDR_W-1:0] WR_FACT_B  = 3'd1;
  localparam logic [ADDR_W-1:0] WR_DIVD_LO = 3'd2;
  localparam logic [ADDR_W-1:0] WR_DIVD_HI = 3'd3;
  localparam logic [ADDR_W-1:0] WR_DIVISOR = 3'd4;

  // read offsets
  localparam logic [ADDR_W-1:0] RD_QUOT_LO = 3'd0;
  localparam logic [ADDR_W-1:0] RD_QUOT_HI = 3'd1;
  localparam logic [ADDR_W-1:0] RD_RES_LO  = 3'd2;
  localparam logic [ADDR_W-1:0] RD_RES_HI  = 3'd3;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_MUL  = 2'd1,
    OP_DIV  = 2'd2
  } mduOp_t;

  // strobes from control to datapath
  typedef struct packed {
    logic setA;
    logic setDivLo;
    logic setDivHi;
    logic loadMul;
    logic loadDiv;
    logic stepMul;
    logic stepDiv;
  } mduStrobe_t;

endpackage

// File: rtl/mduCtrl.sv
module mduCtrl
  import mduPkg::*;
#(
  parameter int OPW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output mduStrobe_t        strobe,
  output logic              busy
);

  localparam int MUL_STEPS = OPW;
  localparam int DIV_STEPS = 2 * OPW;
  localparam int CW        = $clog2(DIV_STEPS);
  localparam logic [CW-1:0] MUL_LAST = CW'(MUL_STEPS - 1);
  localparam logic [CW-1:0] DIV_LAST = CW'(DIV_STEPS - 1);

  mduOp_t        opReg;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lastCnt;
  logic          startAny;

  always_comb begin
    strobe          = '0;
    strobe.setA     = wrEn && (wrAddr == WR_FACT_A);
    strobe.setDivLo = wrEn && (wrAddr == WR_DIVD_LO);
    strobe.setDivHi = wrEn && (wrAddr == WR_DIVD_HI);
    strobe.loadMul  = wrEn && (wrAddr == WR_FACT_B);
    strobe.loadDiv  = wrEn && (wrAddr == WR_DIVISOR);
    startAny        = strobe.loadMul || strobe.loadDiv;
    // a fresh start overrides any step of the old operation
    strobe.stepMul  = busy && (opReg == OP_MUL) && !startAny;
    strobe.stepDiv  = busy && (opReg == OP_DIV) && !startAny;
    lastCnt         = (opReg == OP_MUL) ? MUL_LAST : DIV_LAST;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opReg <= OP_IDLE;
      cnt   <= '0;
      busy  <= 1'b0;
    end else if (startAny) begin
      opReg <= strobe.loadMul ? OP_MUL : OP_DIV;
      cnt   <= '0;
      busy  <= 1'b1;
    end else if (busy) begin
      if (cnt == lastCnt) begin
        busy  <= 1'b0;
        opReg <= OP_IDLE;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R9: a start write makes the unit busy on the next cycle
  p_start_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (wrAddr == WR_FACT_B || wrAddr == WR_DIVISOR)) |=> busy);

  // R9: a multiply only ends after its last step
  p_mul_len_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && opReg == OP_MUL && !startAny && cnt != MUL_LAST) |=> busy);

  // R9: a divide only ends after its last step
  p_div_len_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && opReg == OP_DIV && !startAny && cnt != DIV_LAST) |=> busy);

  // R3: operand-only writes while idle never start anything
  p_no_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && wrEn && (wrAddr == WR_FACT_A || wrAddr == WR_DIVD_LO ||
                       wrAddr == WR_DIVD_HI)) |=> !busy);

  // R9: busy and the idle op code agree
  p_op_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy == (opReg != OP_IDLE));

endmodule

// File: rtl/mduDatapath.sv
module mduDatapath
  import mduPkg::*;
#(
  parameter int OPW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [OPW-1:0]    wrData,
  input  mduStrobe_t        strobe,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [OPW-1:0]    rdData
);

  localparam int DW = 2 * OPW;

  logic [OPW-1:0] factA;
  logic [DW-1:0]  dividend;
  logic [DW-1:0]  mcand;
  logic [OPW-1:0] mplier;
  logic [OPW-1:0] divWork;
  logic [DW-1:0]  quotReg;
  logic [DW-1:0]  resultReg;

  logic [DW:0] shifted;
  logic [DW:0] divExt;
  logic [DW:0] diff;
  logic        fits;

  // one restoring-division step
  always_comb begin
    shifted = {resultReg, quotReg[DW-1]};
    divExt  = {{(DW+1-OPW){1'b0}}, divWork};
    diff    = shifted - divExt;
    fits    = (shifted >= divExt);
  end

  // operand holding registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      factA    <= '0;
      dividend <= '0;
    end else begin
      if (strobe.setA)     factA                 <= wrData;
      if (strobe.setDivLo) dividend[OPW-1:0]     <= wrData;
      if (strobe.setDivHi) dividend[DW-1:OPW]    <= wrData;
    end
  end

  // working registers and results
  always_ff @(posedge clk) begin
    if (!rstN) begin
      mcand     <= '0;
      mplier    <= '0;
      divWork   <= '0;
      quotReg   <= '0;
      resultReg <= '0;
    end else if (strobe.loadMul) begin
      mcand     <= {{OPW{1'b0}}, factA};
      mplier    <= wrData;
      resultReg <= '0;
    end else if (strobe.loadDiv) begin
      divWork   <= wrData;
      quotReg   <= dividend;
      resultReg <= '0;
    end else if (strobe.stepMul) begin
      if (mplier[0]) resultReg <= resultReg + mcand;
      mcand  <= mcand << 1;
      mplier <= mplier >> 1;
    end else if (strobe.stepDiv) begin
      if (fits) begin
        resultReg <= diff[DW-1:0];
        quotReg   <= {quotReg[DW-2:0], 1'b1};
      end else begin
        resultReg <= shifted[DW-1:0];
        quotReg   <= {quotReg[DW-2:0], 1'b0};
      end
    end
  end

  always_comb begin
    case (rdAddr)
      RD_QUOT_LO: rdData = quotReg[OPW-1:0];
      RD_QUOT_HI: rdData = quotReg[DW-1:OPW];
      RD_RES_LO:  rdData = resultReg[OPW-1:0];
      RD_RES_HI:  rdData = resultReg[DW-1:OPW];
      default:    rdData = '0;
    endcase
  end

  // R6: multiply steps never disturb the quotient
  p_quot_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stepMul |=> $stable(quotReg));

  // R4: remainder stays below a nonzero divisor after each step
  p_rem_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepDiv && divWork != '0) |=> (resultReg < {{OPW{1'b0}}, divWork}));

  // R7: partial products never shrink
  p_prod_grow_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stepMul |=> (resultReg >= $past(resultReg)));

  // R5: a zero divisor sets every quotient bit
  p_zero_div_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepDiv && divWork == '0) |=> quotReg[0]);

  // R10: unmapped offsets read zero
  p_unmapped_r10: assert property (@(posedge clk) disable iff (!rstN)
    rdAddr[ADDR_W-1] |-> (rdData == '0));

endmodule

// File: rtl/mulDivUnit.sv
module mulDivUnit
  import mduPkg::*;
#(
  parameter int OPW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [OPW-1:0]    wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [OPW-1:0]    rdData,
  output logic              busy
);

  mduStrobe_t strobe;

  mduCtrl #(.OPW(OPW)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .strobe (strobe),
    .busy   (busy)
  );

  mduDatapath #(.OPW(OPW)) uPath (
    .clk    (clk),
    .rstN   (rstN),
    .wrData (wrData),
    .strobe (strobe),
    .rdAddr (rdAddr),
    .rdData (rdData)
  );

endmodule

// File: tb/mulDivUnit_test.sv
module mulDivUnit_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [2:0] rdAddr = '0;
  logic [7:0] rdData;
  logic       busy;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mulDivUnit uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .busy(busy)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd16(input logic [2:0] lo, output logic [15:0] v);
    rdAddr = lo;       #1; v[7:0]  = rdData;
    rdAddr = lo + 3'd1; #1; v[15:8] = rdData;
  endtask

  task automatic runMul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] v;
    wr(3'd0, a);
    wr(3'd1, b);
    check("R9 busy after mul start", {15'd0, busy}, 16'd1);
    repeat (7) @(negedge clk);
    check("R9 busy at mul step 7", {15'd0, busy}, 16'd1);
    @(negedge clk);
    check("R9 busy after mul step 8", {15'd0, busy}, 16'd0);
    rd16(3'd2, v);
    check("R2 product", v, 16'(a) * 16'(b));
  endtask

  task automatic runDiv(input logic [15:0] n, input logic [7:0] d);
    logic [15:0] q, r;
    wr(3'd2, n[7:0]);
    wr(3'd3, n[15:8]);
    wr(3'd4, d);
    repeat (15) @(negedge clk);
    check("R9 busy at div step 15", {15'd0, busy}, 16'd1);
    @(negedge clk);
    check("R9 busy after div step 16", {15'd0, busy}, 16'd0);
    rd16(3'd0, q);
    rd16(3'd2, r);
    if (d == 0) begin
      check("R5 zero-div quotient", q, 16'hFFFF);
      check("R5 zero-div remainder", r, n);
    end else begin
      check("R4 quotient", q, n / 16'(d));
      check("R4 remainder", r, n % 16'(d));
    end
  endtask

  task automatic testReset();
    check("R1 busy reset", {15'd0, busy}, 16'd0);
    for (int i = 0; i < 8; i++) begin
      rdAddr = 3'(i); #1;
      check("R1 read reset", {8'd0, rdData}, 16'd0);
    end
  endtask

  task automatic testCorners();
    runMul(8'h00, 8'hFF);
    runMul(8'hFF, 8'hFF);
    runMul(8'h01, 8'h80);
    runDiv(16'hFFFF, 8'hFF);
    runDiv(16'hFFFF, 8'h01);
    runDiv(16'h0000, 8'h07);
    runDiv(16'h0005, 8'h09);
  endtask

  task automatic testZeroDiv();
    runDiv(16'hBEEF, 8'h00);
    runDiv(16'h0000, 8'h00);
  endtask

  task automatic testShared();
    logic [15:0] q0, v;
    runDiv(16'h1234, 8'h10);
    rd16(3'd0, q0);
    runMul(8'h3C, 8'hA5);
    rd16(3'd0, v);
    check("R6 quotient kept by mul", v, q0);
    runDiv(16'h8001, 8'h03);
    rd16(3'd2, v);
    check("R6 remainder replaces product", v, 16'h8001 % 16'd3);
  endtask

  task automatic testPartial();
    logic [15:0] v;
    logic [7:0] a = 8'hB7, b = 8'hDB;
    wr(3'd0, a);
    wr(3'd1, b);
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      rd16(3'd2, v);
      check("R7 partial product", v, 16'(a) * (16'(b) & ((16'd1 << k) - 16'd1)));
    end
  endtask

  task automatic testRestart();
    logic [15:0] v;
    wr(3'd0, 8'h55);
    wr(3'd1, 8'h0F);
    repeat (3) @(negedge clk);
    wr(3'd1, 8'hF3);
    repeat (7) @(negedge clk);
    check("R8 busy after mul restart", {15'd0, busy}, 16'd1);
    @(negedge clk);
    check("R8 idle after restarted mul", {15'd0, busy}, 16'd0);
    rd16(3'd2, v);
    check("R8 restarted product", v, 16'h55 * 16'hF3);
    wr(3'd2, 8'h39);
    wr(3'd3, 8'hA7);
    wr(3'd1, 8'h77);
    @(negedge clk);
    wr(3'd4, 8'h2B);
    repeat (15) @(negedge clk);
    check("R8 busy through div after mul abandon", {15'd0, busy}, 16'd1);
    @(negedge clk);
    rd16(3'd0, v);
    check("R8 quotient after abandon", v, 16'hA739 / 16'h2B);
    rd16(3'd2, v);
    check("R8 remainder after abandon", v, 16'hA739 % 16'h2B);
  endtask

  task automatic testNoStart();
    logic [15:0] q0, r0, v;
    rd16(3'd0, q0);
    rd16(3'd2, r0);
    wr(3'd0, 8'hAA);
    check("R3 no start on A write", {15'd0, busy}, 16'd0);
    wr(3'd2, 8'h11);
    wr(3'd3, 8'h22);
    check("R3 no start on dividend write", {15'd0, busy}, 16'd0);
    repeat (3) @(negedge clk);
    rd16(3'd0, v);
    check("R3 quotient untouched", v, q0);
    rd16(3'd2, v);
    check("R3 result untouched", v, r0);
  endtask

  task automatic testUnmapped();
    for (int i = 4; i < 8; i++) begin
      rdAddr = 3'(i); #1;
      check("R10 unmapped read", {8'd0, rdData}, 16'd0);
    end
  endtask

  task automatic testRandom();
    for (int i = 0; i < 25; i++) begin
      runMul(8'($urandom), 8'($urandom));
      runDiv(16'($urandom), 8'($urandom));
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testUnmapped();
    testCorners();
    testZeroDiv();
    testShared();
    testPartial();
    testRestart();
    testNoStart();
    testRandom();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule